// File: doc/BRIEF.md
# Two-Level Switch Path Controller

This block is the digital control plane of a two-level switched fabric that joins a host port to a set of compute arrays. A central router sits next to the host converters. It has one uplink port to each of four group routers. Each group router serves four local arrays. Software writes each task's route beforehand as a short list of hops, with one hop per network layer. Each hop names a group and an array inside that group. The controller computes no routes itself.

Work starts when a task's input token arrives. No start command exists. The controller closes the host-to-group uplink and the array port for the task's first hop. From then on, each hop-complete token returned by an array opens that array's port and closes the port of the next hop. A hop that stays inside a group uses only the group router. A hop into another group travels through the central router again, so the uplink of the new group is closed. After the task's last hop the result goes back through the central router toward the output converter. The controller then opens every switch the task held and raises a one-cycle done flag for that task.

The data plane is modelled as tagged tokens. Input and hop tokens each carry a task number. The outputs are the switch select vectors and per-task done and error flags.

Top module: `hpc_path_top`

## Requirements
- R1: After reset, every array select and uplink select is open, no done or error flag is raised, and every route slot is empty.
- R2: An accepted input token whose first hop is {g,a} closes array select bit g*4+a and uplink select bit g from the next cycle on.
- R3: A hop-complete token whose next hop lies in the same group moves the array select to the new array and opens the uplink select of that group.
- R4: A hop-complete token whose next hop lies in another group moves the array select and moves the uplink select to the new group.
- R5: A hop-complete token for a hop marked last opens all selects of that task and raises done bit t for exactly one cycle, in the cycle after acceptance.
- R6: An input token stalls (inReady low) while another task holds its target array port or the uplink of its target group. It is accepted once that claim is released.
- R7: A hop-complete token stalls (hopReady low) while another task holds the next hop's array port, or holds the uplink that a cross-group move needs. All selects stay unchanged during the stall.
- R8: A token whose target slot holds no valid entry is accepted and dropped. Error bit t then pulses for one cycle and the task holds no select afterwards.
- R9: An input token for a task that is already running stalls.
- R10: A configuration write with the valid field low clears that slot, so a later input for that slot ends in an error rather than a path.
- R11: When a hop-complete token and an input token contend for the same port in one cycle, the hop token wins and the input token stalls.
- R12: A task holds at most four hops. A hop-complete token on the fourth hop that is not marked last raises the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Route slot write strobe |
| cfgTask | input | 1 | Task whose route is written |
| cfgSlot | input | 2 | Hop position within the route |
| cfgValid | input | 1 | Slot holds a hop (0 clears it) |
| cfgLast | input | 1 | This hop ends the route |
| cfgGroup | input | 2 | Destination group of the hop |
| cfgArray | input | 2 | Destination array inside the group |
| inValid | input | 1 | Input token present |
| inTask | input | 1 | Task tag of the input token |
| inReady | output | 1 | Input token accepted this cycle when valid |
| hopValid | input | 1 | Hop-complete token present |
| hopTask | input | 1 | Task tag of the hop-complete token |
| hopReady | output | 1 | Hop token accepted this cycle when valid |
| arraySel | output | 16 | Closed group-router array ports, bit g*4+a |
| linkSel | output | 4 | Closed central-router uplink ports, bit g |
| doneVec | output | 2 | One-cycle completion flag per task |
| errVec | output | 2 | One-cycle missing-route flag per task |

## Verification
The assertions assume three things about the inputs. Route slots are written only while their task is idle. A task is running whenever a hop-complete token arrives for it. Only one token of each kind is offered per cycle. The bench follows these rules: it writes each route before the scenario that uses it, and it lets every task finish or fail before the next scenario starts. Spurious hop tokens are never offered. Stalled tokens are withdrawn before the clock edge, which makes every stall visible through the ready signal and the unchanged selects.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int GRP_W  = 2;
  localparam int ARR_W  = 2;
  localparam int TASK_W = 1;
  localparam int HOP_W  = 2;
  localparam int NUM_GROUPS       = 1 << GRP_W;
  localparam int ARRAYS_PER_GROUP = 1 << ARR_W;
  localparam int NUM_TASKS        = 1 << TASK_W;
  localparam int MAX_HOPS         = 1 << HOP_W;
  localparam int NUM_ARRAYS       = NUM_GROUPS * ARRAYS_PER_GROUP;

  typedef struct packed {
    logic             valid;
    logic             last;
    logic [GRP_W-1:0] grp;
    logic [ARR_W-1:0] arr;
  } hop_t;

  typedef struct packed {
    logic              advance;
    logic              rewind;
    logic [TASK_W-1:0] tid;
  } strobe_t;
endpackage

// File: rtl/hpc_route_store.sv
module hpc_route_store
  import hpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [TASK_W-1:0] cfgTask,
  input  logic [HOP_W-1:0]  cfgSlot,
  input  hop_t              cfgEntry,
  input  strobe_t           strobe,
  output hop_t              curEntry  [NUM_TASKS],
  output hop_t              nextEntry [NUM_TASKS]
);
  localparam logic [HOP_W-1:0] LAST_SLOT = HOP_W'(MAX_HOPS - 1);

  hop_t             routeTbl [NUM_TASKS][MAX_HOPS];
  logic [HOP_W-1:0] hopCnt   [NUM_TASKS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_TASKS; t++) begin
        hopCnt[t] <= '0;
        for (int h = 0; h < MAX_HOPS; h++) routeTbl[t][h] <= '0;
      end
    end else begin
      if (cfgWe) routeTbl[cfgTask][cfgSlot] <= cfgEntry;
      if (strobe.rewind)       hopCnt[strobe.tid] <= '0;
      else if (strobe.advance) hopCnt[strobe.tid] <= hopCnt[strobe.tid] + 1'b1;
    end
  end

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_view
    logic [HOP_W-1:0] nxtIdx;
    assign nxtIdx       = hopCnt[t] + 1'b1;
    assign curEntry[t]  = routeTbl[t][hopCnt[t]];
    assign nextEntry[t] = (hopCnt[t] == LAST_SLOT) ? '0 : routeTbl[t][nxtIdx];
  end

  // R12
  counter_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> hopCnt[strobe.tid] != LAST_SLOT);
endmodule

// File: rtl/hpc_path_ctrl.sv
module hpc_path_ctrl
  import hpc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [TASK_W-1:0]     inTask,
  output logic                  inReady,
  input  logic                  hopValid,
  input  logic [TASK_W-1:0]     hopTask,
  output logic                  hopReady,
  input  hop_t                  curEntry  [NUM_TASKS],
  input  hop_t                  nextEntry [NUM_TASKS],
  output strobe_t               strobe,
  output logic [NUM_ARRAYS-1:0] arraySel,
  output logic [NUM_GROUPS-1:0] linkSel,
  output logic [NUM_TASKS-1:0]  doneVec,
  output logic [NUM_TASKS-1:0]  errVec
);
  logic [NUM_TASKS-1:0] busy, viaCtr;

  function automatic int flatIdx(hop_t h);
    return int'(h.grp) * ARRAYS_PER_GROUP + int'(h.arr);
  endfunction

  hop_t hopCur, hopNxt, inFirst;
  logic hopBusy, hopLast, hopErr, hopCross, hopConflict, hopFire, hopFwd;
  logic inErr, inConflict, inFire;

  // hop-complete token: finish, fail or forward
  always_comb begin
    hopCur   = curEntry[hopTask];
    hopNxt   = nextEntry[hopTask];
    hopBusy  = busy[hopTask];
    hopLast  = hopBusy && hopCur.last;
    hopErr   = !hopBusy || (!hopCur.last && !hopNxt.valid);
    hopCross = hopNxt.grp != hopCur.grp;
    hopConflict = 1'b0;
    for (int t = 0; t < NUM_TASKS; t++) begin
      if (busy[t] && TASK_W'(t) != hopTask) begin
        if (flatIdx(curEntry[t]) == flatIdx(hopNxt)) hopConflict = 1'b1;
        if (hopCross && viaCtr[t] && curEntry[t].grp == hopNxt.grp) hopConflict = 1'b1;
      end
    end
    hopReady = hopLast || hopErr || !hopConflict;
    hopFire  = hopValid && hopReady;
    hopFwd   = hopFire && !hopLast && !hopErr;
  end

  // input token: always enters its group through the central router
  always_comb begin
    inFirst    = curEntry[inTask];
    inErr      = !inFirst.valid;
    inConflict = 1'b0;
    for (int t = 0; t < NUM_TASKS; t++) begin
      if (busy[t]) begin
        if (flatIdx(curEntry[t]) == flatIdx(inFirst)) inConflict = 1'b1;
        if (viaCtr[t] && curEntry[t].grp == inFirst.grp) inConflict = 1'b1;
      end
    end
    if (hopFwd) begin
      if (flatIdx(hopNxt) == flatIdx(inFirst)) inConflict = 1'b1;
      if (hopCross && hopNxt.grp == inFirst.grp) inConflict = 1'b1;
    end
    inReady = !busy[inTask] && (inErr || !inConflict);
    inFire  = inValid && inReady;
  end

  always_comb begin
    strobe.tid     = hopTask;
    strobe.advance = hopFwd;
    strobe.rewind  = hopFire && hopBusy && (hopLast || hopErr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= '0;
      viaCtr  <= '0;
      doneVec <= '0;
      errVec  <= '0;
    end else begin
      doneVec <= '0;
      errVec  <= '0;
      if (hopFire) begin
        if (!hopBusy) begin
          errVec[hopTask] <= 1'b1;
        end else if (hopLast) begin
          busy[hopTask]    <= 1'b0;
          doneVec[hopTask] <= 1'b1;
        end else if (hopErr) begin
          busy[hopTask]   <= 1'b0;
          errVec[hopTask] <= 1'b1;
        end else begin
          viaCtr[hopTask] <= hopCross;
        end
      end
      if (inFire) begin
        if (inErr) begin
          errVec[inTask] <= 1'b1;
        end else begin
          busy[inTask]   <= 1'b1;
          viaCtr[inTask] <= 1'b1;
        end
      end
    end
  end

  // switch selects from the claims of running tasks
  always_comb begin
    arraySel = '0;
    linkSel  = '0;
    for (int t = 0; t < NUM_TASKS; t++) begin
      if (busy[t]) begin
        arraySel[flatIdx(curEntry[t])] = 1'b1;
        if (viaCtr[t]) linkSel[curEntry[t].grp] = 1'b1;
      end
    end
  end

  logic dupArray, dupLink;
  always_comb begin
    dupArray = 1'b0;
    dupLink  = 1'b0;
    for (int a = 0; a < NUM_TASKS; a++)
      for (int b = a + 1; b < NUM_TASKS; b++)
        if (busy[a] && busy[b]) begin
          if (flatIdx(curEntry[a]) == flatIdx(curEntry[b])) dupArray = 1'b1;
          if (viaCtr[a] && viaCtr[b] && curEntry[a].grp == curEntry[b].grp) dupLink = 1'b1;
        end
  end

  // R6
  no_shared_array_chk: assert property (@(posedge clk) disable iff (!rstN) !dupArray);
  // R7
  no_shared_link_chk: assert property (@(posedge clk) disable iff (!rstN) !dupLink);
  // R5
  done_after_hop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|doneVec) |-> $past(hopValid && hopReady));
  // R8
  err_after_token_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|errVec) |-> $past((hopValid && hopReady) || (inValid && inReady)));
  // R2
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_linkchk
    link_has_array_chk: assert property (@(posedge clk) disable iff (!rstN)
      linkSel[g] |-> (|arraySel[g*ARRAYS_PER_GROUP +: ARRAYS_PER_GROUP]));
  end
endmodule

// File: rtl/hpc_path_top.sv
module hpc_path_top
  import hpc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [TASK_W-1:0]     cfgTask,
  input  logic [HOP_W-1:0]      cfgSlot,
  input  logic                  cfgValid,
  input  logic                  cfgLast,
  input  logic [GRP_W-1:0]      cfgGroup,
  input  logic [ARR_W-1:0]      cfgArray,
  input  logic                  inValid,
  input  logic [TASK_W-1:0]     inTask,
  output logic                  inReady,
  input  logic                  hopValid,
  input  logic [TASK_W-1:0]     hopTask,
  output logic                  hopReady,
  output logic [NUM_ARRAYS-1:0] arraySel,
  output logic [NUM_GROUPS-1:0] linkSel,
  output logic [NUM_TASKS-1:0]  doneVec,
  output logic [NUM_TASKS-1:0]  errVec
);
  hop_t    cfgEntry;
  hop_t    curEntry  [NUM_TASKS];
  hop_t    nextEntry [NUM_TASKS];
  strobe_t strobe;

  assign cfgEntry = '{valid: cfgValid, last: cfgLast, grp: cfgGroup, arr: cfgArray};

  hpc_route_store u_store (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgTask(cfgTask), .cfgSlot(cfgSlot),
    .cfgEntry(cfgEntry), .strobe(strobe), .curEntry(curEntry), .nextEntry(nextEntry)
  );

  hpc_path_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTask(inTask), .inReady(inReady),
    .hopValid(hopValid), .hopTask(hopTask), .hopReady(hopReady),
    .curEntry(curEntry), .nextEntry(nextEntry), .strobe(strobe),
    .arraySel(arraySel), .linkSel(linkSel), .doneVec(doneVec), .errVec(errVec)
  );
endmodule

// File: tb/tb_hpc_path_top.sv
`timescale 1ns/1ps
module tb_hpc_path_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0, cfgTask = 0, cfgValid = 0, cfgLast = 0;
  logic [1:0] cfgSlot = 0, cfgGroup = 0, cfgArray = 0;
  logic inValid = 0, inTask = 0, hopValid = 0, hopTask = 0;
  logic inReady, hopReady;
  logic [15:0] arraySel;
  logic [3:0] linkSel;
  logic [1:0] doneVec, errVec;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  hpc_path_top dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgTask(cfgTask), .cfgSlot(cfgSlot),
    .cfgValid(cfgValid), .cfgLast(cfgLast), .cfgGroup(cfgGroup), .cfgArray(cfgArray),
    .inValid(inValid), .inTask(inTask), .inReady(inReady),
    .hopValid(hopValid), .hopTask(hopTask), .hopReady(hopReady),
    .arraySel(arraySel), .linkSel(linkSel), .doneVec(doneVec), .errVec(errVec)
  );

  function automatic logic [15:0] sel(int g, int a);
    return 16'(1) << (g * 4 + a);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic writeHop(int t, int slot, bit v, bit last, int g, int a);
    @(negedge clk);
    cfgWe = 1; cfgTask = t[0]; cfgSlot = slot[1:0]; cfgValid = v; cfgLast = last;
    cfgGroup = g[1:0]; cfgArray = a[1:0];
    @(posedge clk); #1 cfgWe = 0;
  endtask

  task automatic offerIn(int t, bit expReady, string req);
    @(negedge clk);
    inValid = 1; inTask = t[0]; #1;
    chk(req, "inReady", 32'(inReady), 32'(expReady));
    if (inReady) begin @(posedge clk); #1; end
    inValid = 0;
  endtask

  task automatic offerHop(int t, bit expReady, string req);
    @(negedge clk);
    hopValid = 1; hopTask = t[0]; #1;
    chk(req, "hopReady", 32'(hopReady), 32'(expReady));
    if (hopReady) begin @(posedge clk); #1; end
    hopValid = 0;
  endtask

  task automatic look(string req, logic [15:0] s, logic [3:0] l, logic [1:0] d, logic [1:0] e);
    @(negedge clk); #1;
    chk(req, "arraySel", 32'(arraySel), 32'(s));
    chk(req, "linkSel", 32'(linkSel), 32'(l));
    chk(req, "doneVec", 32'(doneVec), 32'(d));
    chk(req, "errVec", 32'(errVec), 32'(e));
  endtask

  // R1 R10: idle state, empty slots turn an input into an error
  task automatic testReset();
    look("R1", 16'h0, 4'h0, 2'b00, 2'b00);
    offerIn(0, 1'b1, "R1");
    look("R10", 16'h0, 4'h0, 2'b00, 2'b01);
  endtask

  // R2 R3 R5: in-group route
  task automatic testLocal();
    writeHop(0, 0, 1, 0, 1, 2);
    writeHop(0, 1, 1, 1, 1, 0);
    offerIn(0, 1'b1, "R2");
    look("R2", sel(1, 2), 4'b0010, 2'b00, 2'b00);
    offerHop(0, 1'b1, "R3");
    look("R3", sel(1, 0), 4'b0000, 2'b00, 2'b00);
    offerHop(0, 1'b1, "R5");
    look("R5", 16'h0, 4'h0, 2'b01, 2'b00);
    look("R5", 16'h0, 4'h0, 2'b00, 2'b00);
  endtask

  // R4: cross-group route through the central router
  task automatic testCross();
    writeHop(0, 0, 1, 0, 0, 1);
    writeHop(0, 1, 1, 0, 3, 3);
    writeHop(0, 2, 1, 1, 2, 0);
    offerIn(0, 1'b1, "R4");
    look("R4", sel(0, 1), 4'b0001, 2'b00, 2'b00);
    offerHop(0, 1'b1, "R4");
    look("R4", sel(3, 3), 4'b1000, 2'b00, 2'b00);
    offerHop(0, 1'b1, "R4");
    look("R4", sel(2, 0), 4'b0100, 2'b00, 2'b00);
    offerHop(0, 1'b1, "R5");
    look("R5", 16'h0, 4'h0, 2'b01, 2'b00);
  endtask

  // R6: input stalls on a held array, then on a held uplink
  task automatic testInStall();
    writeHop(0, 0, 1, 1, 2, 1);
    writeHop(1, 0, 1, 1, 2, 1);
    offerIn(0, 1'b1, "R6");
    offerIn(1, 1'b0, "R6");
    look("R6", sel(2, 1), 4'b0100, 2'b00, 2'b00);
    writeHop(1, 0, 1, 1, 2, 3);
    offerIn(1, 1'b0, "R6");
    offerHop(0, 1'b1, "R6");
    look("R6", 16'h0, 4'h0, 2'b01, 2'b00);
    offerIn(1, 1'b1, "R6");
    look("R6", sel(2, 3), 4'b0100, 2'b00, 2'b00);
    offerHop(1, 1'b1, "R6");
    look("R6", 16'h0, 4'h0, 2'b10, 2'b00);
  endtask

  // R7: hop stalls on an array held by the other task
  task automatic testHopStall();
    writeHop(0, 0, 1, 0, 0, 0);
    writeHop(0, 1, 1, 1, 1, 1);
    writeHop(1, 0, 1, 1, 1, 1);
    offerIn(1, 1'b1, "R7");
    offerIn(0, 1'b1, "R7");
    look("R7", sel(1, 1) | sel(0, 0), 4'b0011, 2'b00, 2'b00);
    offerHop(0, 1'b0, "R7");
    look("R7", sel(1, 1) | sel(0, 0), 4'b0011, 2'b00, 2'b00);
    offerHop(1, 1'b1, "R7");
    look("R7", sel(0, 0), 4'b0001, 2'b10, 2'b00);
    offerHop(0, 1'b1, "R7");
    look("R7", sel(1, 1), 4'b0010, 2'b00, 2'b00);
    offerHop(0, 1'b1, "R7");
    look("R7", 16'h0, 4'h0, 2'b01, 2'b00);
  endtask

  // R8 R10: missing next hop, cleared first slot
  task automatic testMissing();
    writeHop(0, 0, 1, 0, 3, 2);
    writeHop(0, 1, 0, 0, 0, 0);
    offerIn(0, 1'b1, "R8");
    look("R8", sel(3, 2), 4'b1000, 2'b00, 2'b00);
    offerHop(0, 1'b1, "R8");
    look("R8", 16'h0, 4'h0, 2'b00, 2'b01);
    writeHop(1, 0, 0, 0, 1, 1);
    offerIn(1, 1'b1, "R10");
    look("R10", 16'h0, 4'h0, 2'b00, 2'b10);
  endtask

  // R9: second input for a running task stalls
  task automatic testBusyIn();
    writeHop(0, 0, 1, 0, 0, 2);
    writeHop(0, 1, 1, 1, 0, 3);
    offerIn(0, 1'b1, "R9");
    offerIn(0, 1'b0, "R9");
    look("R9", sel(0, 2), 4'b0001, 2'b00, 2'b00);
    offerHop(0, 1'b1, "R9");
    offerHop(0, 1'b1, "R9");
    look("R9", 16'h0, 4'h0, 2'b01, 2'b00);
  endtask

  // R12: four hops without an end mark
  task automatic testDepth();
    for (int s = 0; s < 4; s++) writeHop(1, s, 1, 0, 0, s);
    offerIn(1, 1'b1, "R12");
    for (int s = 1; s < 4; s++) offerHop(1, 1'b1, "R12");
    look("R12", sel(0, 3), 4'b0000, 2'b00, 2'b00);
    offerHop(1, 1'b1, "R12");
    look("R12", 16'h0, 4'h0, 2'b00, 2'b10);
  endtask

  // R11: hop and input contend for one uplink in the same cycle
  task automatic testPriority();
    writeHop(0, 0, 1, 0, 1, 0);
    writeHop(0, 1, 1, 1, 2, 2);
    writeHop(1, 0, 1, 1, 2, 1);
    offerIn(0, 1'b1, "R11");
    @(negedge clk);
    hopValid = 1; hopTask = 0; inValid = 1; inTask = 1; #1;
    chk("R11", "hopReady", 32'(hopReady), 32'd1);
    chk("R11", "inReady", 32'(inReady), 32'd0);
    @(posedge clk); #1;
    hopValid = 0; inValid = 0;
    look("R11", sel(2, 2), 4'b0100, 2'b00, 2'b00);
    offerHop(0, 1'b1, "R11");
    offerIn(1, 1'b1, "R11");
    look("R11", sel(2, 1), 4'b0100, 2'b00, 2'b00);
    offerHop(1, 1'b1, "R11");
    look("R11", 16'h0, 4'h0, 2'b10, 2'b00);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    testReset();
    testLocal();
    testCross();
    testInStall();
    testHopStall();
    testMissing();
    testBusyIn();
    testDepth();
    testPriority();
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule